// File: doc/BRIEF.md
# I2S Stereo Microphone Capture Master

This block drives a shared two-wire-clock audio bus, on which one or two 24-bit digital microphones put their samples on a single data line. It makes the bit clock from the system clock through a parameterised divider. It makes the word-select signal with exactly 64 bit clocks per stereo frame: the left slot while word-select is low and the right slot while it is high. It shifts in the serial data line and presents each frame's left and right samples together, sign-extended, with a single-cycle valid strobe.

The bit clock runs at the system clock divided by 2×DIV. Word-select only moves on a falling bit-clock edge, and data is sampled on rising edges. In each 32-bit slot the first bit period after the word-select edge is skipped. The next 24 bits are taken MSB first. The rest of the slot, where every microphone has released the line and it is pulled low, is discarded. Deasserting the enable parks the bit clock low and word-select high, so that attached microphones fall into standby. A frame that was cut short is dropped.

Top module: `i2s_mic_rx`

## Requirements
- R1: While enabled, `sck_o` is a square wave with a period of 2×DIV system clocks, high for DIV clocks and low for DIV clocks.
- R2: A stereo frame lasts 64 `sck_o` periods: `ws_o` is low for 32 (left slot) and high for 32 (right slot), and `ws_o` changes only in the cycle in which `sck_o` falls.
- R3: `sd_i` is sampled when `sck_o` rises. In each slot, the bit sampled in slot positions 1 to 24 forms the word MSB first, where position 0 is the bit period that starts at the word-select edge.
- R4: The values on `sd_i` at slot position 0 and at positions 25 to 31 have no effect on the delivered samples.
- R5: Each 24-bit word is two's complement and is delivered on an OUT_W-bit output with bit 23 copied into all upper bits.
- R6: `valid_o` is high for exactly one cycle per frame, 128×DIV system clocks apart, while `ws_o` is high. `left_o` and `right_o` change only in that cycle, together, and carry the left and right words of the same frame.
- R7: While `en_i` is low, `sck_o` is low, `ws_o` is high, `valid_o` stays low and the sample outputs hold their values.
- R8: After `en_i` rises, `ws_o` falls 2×DIV clocks later and starts a left slot, and that first frame is delivered correctly. A frame interrupted by deasserting `en_i` produces no `valid_o`.
- R9: After reset, `sck_o` is 0, `ws_o` is 1, `valid_o` is 0, and both sample outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Runs the bus clocks when high |
| sck_o | output | 1 | Bit clock to the microphones |
| ws_o | output | 1 | Word select, low = left slot |
| sd_i | input | 1 | Shared serial data line |
| left_o | output | OUT_W | Left sample, sign-extended |
| right_o | output | OUT_W | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
A bit counter that is off by one shows up within a single frame. The word-select period at the pins is no longer 64 bit clocks, and the delivered words come back shifted by one bit, so that an MSB-only or LSB-only test pattern doubles, halves or loses its sign. If the skip or idle decoding is wrong, the line's high idle bits enter the word, which is visible at the next strobe when the bench drives ones into unused slot positions around all-zero words. A stuck enable path shows within a few clocks as a bit clock that keeps toggling, or as a late word-select edge.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  // Role of a bit period within one channel slot.
  typedef enum logic [1:0] {
    SLOT_SKEW = 2'd0,  // delay bit right after the word-select edge
    SLOT_DATA = 2'd1,  // one of the word bits, MSB first
    SLOT_IDLE = 2'd2   // line released, pulled low, ignored
  } slot_kind_e;

  function automatic slot_kind_e classify_slot(input int unsigned pos,
                                               input int unsigned word_bits);
    if (pos == 0)              return SLOT_SKEW;
    else if (pos <= word_bits) return SLOT_DATA;
    else                       return SLOT_IDLE;
  endfunction

endpackage

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,   // sck_o goes high at this clock edge
  output logic fall_o    // sck_o goes low at this clock edge
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == LAST);
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/i2s_frame_ctr.sv
module i2s_frame_ctr #(
  parameter int SLOT_BITS = 32,
  localparam int FRAME_BITS = 2 * SLOT_BITS,
  localparam int BIT_W = $clog2(FRAME_BITS),
  localparam int POS_W = $clog2(SLOT_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             fall_i,
  output logic             ws_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] HALF     = BIT_W'(SLOT_BITS);

  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] bit_nxt;
  logic             ws_q;

  assign bit_nxt = (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
  assign ws_o    = ws_q;
  assign pos_o   = (bit_q >= HALF) ? POS_W'(bit_q - HALF) : POS_W'(bit_q);

  // While stopped, park at the last bit of a right slot so that the
  // first falling edge after enable opens a fresh left slot.
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      bit_q <= LAST_BIT;
      ws_q  <= 1'b1;
    end else if (fall_i) begin
      bit_q <= bit_nxt;
      ws_q  <= (bit_nxt >= HALF);
    end
  end

endmodule

// File: rtl/i2s_deser.sv
module i2s_deser
  import i2s_rx_pkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int POS_W     = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 rise_i,
  input  logic                 chan_i,   // 0 = left slot, 1 = right slot
  input  logic [POS_W-1:0]     pos_i,
  input  logic                 sd_i,
  output logic [WORD_BITS-1:0] left_o,
  output logic [WORD_BITS-1:0] right_o,
  output logic                 valid_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_BITS);

  slot_kind_e           kind;
  logic [WORD_BITS-1:0] shreg_q;
  logic [WORD_BITS-1:0] left_hold_q;
  logic [WORD_BITS-1:0] left_q;
  logic [WORD_BITS-1:0] right_q;
  logic                 valid_q;
  logic [WORD_BITS-1:0] word_full;

  assign kind      = classify_slot(int'(pos_i), WORD_BITS);
  assign word_full = {shreg_q[WORD_BITS-2:0], sd_i};
  assign left_o    = left_q;
  assign right_o   = right_q;
  assign valid_o   = valid_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      shreg_q     <= '0;
      left_hold_q <= '0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (rise_i && kind == SLOT_DATA) begin
        shreg_q <= word_full;
        if (pos_i == LAST_POS) begin
          if (!chan_i) begin
            left_hold_q <= word_full;
          end else begin
            left_q  <= left_hold_q;
            right_q <= word_full;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2s_mic_rx.sv
module i2s_mic_rx #(
  parameter int DIV       = 4,
  parameter int SLOT_BITS = 32,
  parameter int WORD_BITS = 24,
  parameter int OUT_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  output logic             sck_o,
  output logic             ws_o,
  input  logic             sd_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);
  localparam int POS_W = $clog2(SLOT_BITS);

  logic                 rise;
  logic                 fall;
  logic [POS_W-1:0]     pos;
  logic [WORD_BITS-1:0] left_w;
  logic [WORD_BITS-1:0] right_w;

  i2s_sck_gen #(.DIV(DIV)) u_sck (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .sck_o (sck_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  i2s_frame_ctr #(.SLOT_BITS(SLOT_BITS)) u_frame (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .fall_i(fall),
    .ws_o  (ws_o),
    .pos_o (pos)
  );

  i2s_deser #(.WORD_BITS(WORD_BITS), .POS_W(POS_W)) u_deser (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .rise_i (rise),
    .chan_i (ws_o),
    .pos_i  (pos),
    .sd_i   (sd_i),
    .left_o (left_w),
    .right_o(right_w),
    .valid_o(valid_o)
  );

  generate
    if (OUT_W > WORD_BITS) begin : g_sext
      assign left_o  = {{(OUT_W-WORD_BITS){left_w[WORD_BITS-1]}},  left_w};
      assign right_o = {{(OUT_W-WORD_BITS){right_w[WORD_BITS-1]}}, right_w};
    end else begin : g_flat
      assign left_o  = left_w;
      assign right_o = right_w;
    end
  endgenerate

endmodule

// File: rtl/i2s_mic_rx_checker.sv
module i2s_mic_rx_checker #(
  parameter int OUT_W = 32
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic             sck_o,
  input logic             ws_o,
  input logic             valid_o,
  input logic [OUT_W-1:0] left_o,
  input logic [OUT_W-1:0] right_o
);

  // R2: word select moves only together with a falling bit clock
  p_ws_on_fall_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(en_i) && !$stable(ws_o)) |-> $fell(sck_o));

  // R6: the strobe lasts a single cycle
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  // R6: the strobe falls inside the right slot
  p_valid_in_right_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> ws_o);

  // R6: sample outputs move only with the strobe
  p_out_with_valid_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(left_o) || !$stable(right_o)) |-> valid_o);

  // R7: disabled bus is parked
  p_parked_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!sck_o && ws_o && !valid_o));

endmodule

bind i2s_mic_rx i2s_mic_rx_checker #(.OUT_W(OUT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .en_i   (en_i),
  .sck_o  (sck_o),
  .ws_o   (ws_o),
  .valid_o(valid_o),
  .left_o (left_o),
  .right_o(right_o)
);

// File: tb/i2s_mic_rx_bench.sv
`timescale 1ns/1ps
module i2s_mic_rx_bench;
  localparam int DIV   = 2;
  localparam int OUT_W = 32;
  localparam int FRAME_CLK = 128 * DIV;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic             sd  = 1'b0;
  logic             sck, ws, valid;
  logic [OUT_W-1:0] left, right;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  i2s_mic_rx #(.DIV(DIV), .OUT_W(OUT_W)) u_i2s_mic_rx (
    .clk_i(clk), .rst_i(rst), .en_i(en), .sck_o(sck), .ws_o(ws),
    .sd_i(sd), .left_o(left), .right_o(right), .valid_o(valid)
  );

  // Microphone-pair model: drives after each falling bit-clock edge.
  logic [23:0] nxt_l = '0, nxt_r = '0, cur_l = '0, cur_r = '0;
  logic        prev_ws  = 1'b1;
  logic        idle_lvl = 1'b0;
  int          pos = 0;

  always begin
    logic [23:0] w;
    @(negedge sck);
    #1;
    if (ws !== prev_ws) pos = 0; else pos++;
    prev_ws = ws;
    if (pos == 0 && !ws) begin cur_l = nxt_l; cur_r = nxt_r; end
    w  = ws ? cur_r : cur_l;
    sd = (pos >= 1 && pos <= 24) ? w[24-pos] : idle_lvl;
  end

  function automatic logic [OUT_W-1:0] sx(input logic [23:0] v);
    return {{(OUT_W-24){v[23]}}, v};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int i = 0; i < 4 * FRAME_CLK; i++) begin
      tick();
      if (valid) begin seen = 1; break; end
    end
  endtask

  task automatic send_check(input logic [23:0] l, input logic [23:0] r,
                            input string req);
    bit s1, s2;
    nxt_l = l; nxt_r = r;
    wait_valid(s1);
    wait_valid(s2);
    chk(req, "strobe seen", 32'(s1 && s2), 32'd1);
    chk(req, "left", left, sx(l));
    chk(req, "right", right, sx(r));
  endtask

  task automatic t_reset();
    repeat (5) tick();
    rst = 1'b0;
    tick();
    chk("R9", "sck", 32'(sck), 32'd0);
    chk("R9", "ws", 32'(ws), 32'd1);
    chk("R9", "valid", 32'(valid), 32'd0);
    chk("R9", "left", left, '0);
    chk("R9", "right", right, '0);
  endtask

  task automatic t_start_and_clocks();
    int n, hi, per, rises, rises_hi, bad;
    logic ps, pw;
    en = 1'b1;
    n = 0;
    do begin tick(); n++; end while (ws && n < 100);
    chk("R8", "enable to ws fall", 32'(n), 32'(2 * DIV));
    // R1: period and high time of the bit clock
    ps = sck;
    do begin ps = sck; tick(); end while (!(sck && !ps));
    per = 0; hi = 0;
    do begin
      if (sck) hi++;
      ps = sck; tick(); per++;
    end while (!(sck && !ps));
    chk("R1", "sck period", 32'(per), 32'(2 * DIV));
    chk("R1", "sck high time", 32'(hi), 32'(DIV));
    // R2: frame length and slot split
    pw = ws;
    do begin pw = ws; tick(); end while (!(pw && !ws));
    rises = 0; rises_hi = 0; bad = 0; ps = sck; pw = ws;
    do begin
      ps = sck; pw = ws; tick();
      if (sck && !ps) begin rises++; if (ws) rises_hi++; end
      if (ws !== pw && !(ps && !sck)) bad++;
    end while (!(pw && !ws));
    chk("R2", "sck per frame", 32'(rises), 32'd64);
    chk("R2", "sck in right slot", 32'(rises_hi), 32'd32);
    chk("R2", "ws moves off sck fall", 32'(bad), 32'd0);
  endtask

  task automatic t_patterns();
    send_check(24'h7FFFFF, 24'h800000, "R3 R5");
    send_check(24'hFFFFFF, 24'h000001, "R5");
    send_check(24'hA5A5A5, 24'h5A5A5A, "R3");
    send_check(24'h123456, 24'hFEDCBA, "R3 R6");
  endtask

  task automatic t_idle_ones();
    idle_lvl = 1'b1;
    send_check(24'h000000, 24'h000000, "R4");
    send_check(24'h800001, 24'h400002, "R4");
    idle_lvl = 1'b0;
  endtask

  task automatic t_strobe();
    bit s;
    int gap;
    logic [OUT_W-1:0] l0;
    wait_valid(s);
    tick();
    chk("R6", "strobe width", 32'(valid), 32'd0);
    l0 = left; gap = 1;
    while (!valid && gap < 4 * FRAME_CLK) begin
      if (left !== l0) break;
      tick(); gap++;
    end
    chk("R6", "strobe spacing", 32'(gap), 32'(FRAME_CLK));
  endtask

  task automatic t_disable();
    int s_hi, w_lo, v_n;
    logic [OUT_W-1:0] l0, r0;
    l0 = left; r0 = right;
    en = 1'b0;
    repeat (4) tick();
    prev_ws = 1'b1;
    s_hi = 0; w_lo = 0; v_n = 0;
    repeat (300) begin
      tick();
      if (sck) s_hi++;
      if (!ws) w_lo++;
      if (valid) v_n++;
    end
    chk("R7", "sck high while off", 32'(s_hi), 32'd0);
    chk("R7", "ws low while off", 32'(w_lo), 32'd0);
    chk("R7", "strobes while off", 32'(v_n), 32'd0);
    chk("R7", "left held", left, l0);
    chk("R7", "right held", right, r0);
    en = 1'b1;
    send_check(24'h0F0F0F, 24'hF0F0F0, "R8");
  endtask

  task automatic t_cut_frame();
    int v_n;
    send_check(24'h111111, 24'h222222, "R6");
    nxt_l = 24'h333333; nxt_r = 24'h444444;
    repeat (200) tick();   // inside the right slot of the next frame
    en = 1'b0;
    repeat (4) tick();
    prev_ws = 1'b1;
    v_n = 0;
    repeat (400) begin tick(); if (valid) v_n++; end
    chk("R8", "cut frame strobes", 32'(v_n), 32'd0);
    chk("R8", "cut frame left", left, sx(24'h111111));
    en = 1'b1;
    send_check(24'h876543, 24'h0ABCDE, "R8");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_start_and_clocks();
    t_patterns();
    t_idle_ones();
    t_strobe();
    t_disable();
    t_cut_frame();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule